// File: doc/BRIEF.md
# Saturating Single-Precision Float Divider

This block divides one 32-bit single-precision value by another using a simplified, trap-free arithmetic model. Every exponent field value from 1 to 255 is an ordinary finite number. There are no infinities and no not-a-number codes, and denormal inputs count as zero. Results are truncated toward zero, and no guard, round or sticky bits are kept. Abnormal cases never raise an exception. Each one produces a defined value and a flag.

A caller pulses `start` while the block is idle and presents both operands in that cycle. The quotient mantissa comes from a restoring division loop that retires one bit per cycle over 25 bits: 24 significant bits plus one bit for normalisation. After that loop the sign, exponent and saturation logic packs the result into a registered output word, and `done` pulses for one cycle. Every operation takes the same number of cycles, including division by zero and a zero dividend.

Top module: `fdiv_top`

## Requirements
- R1: The result, `div_zero` and `overflow` are updated, and `done` is high for exactly one cycle, 26 clock edges after the edge that accepted `start`. `busy` is high from the edge after acceptance until `done` is raised, and the output word does not change while `busy` is high.
- R2: A `start` that arrives while `busy` is high is ignored. The operation in flight keeps its operands and its timing.
- R3: The result sign, bit 31, is the XOR of the two operand sign bits. This also applies to the saturated and zero results.
- R4: For normal operands, the quotient mantissa is floor(mA·2^24 / mB), where m = 2^23 + fraction. If bit 24 of that value is set, the fraction is bits 23..1 and the biased exponent is eA − eB + 127. Otherwise the fraction is bits 22..0 and the exponent is eA − eB + 126. No rounding is applied.
- R5: When the divisor's exponent field (bits 30..23) is zero, the result is sign | 0x7FFFFFFF with `div_zero`=1 and `overflow`=0, whatever the dividend is (0/0 included).
- R6: When the divisor's exponent field is nonzero and the dividend's is zero, the result is a signed zero and both flags are 0.
- R7: An exponent field of 255 is an ordinary number: 0/0x7FC00000 gives 0x00000000, 0x7F800000/0x3F800000 gives 0x7F800000, and 0x7FC00000/0x7FC00000 gives 0x3F800000.
- R8: When the computed biased exponent is above 255, the result is sign | 0x7FFFFFFF with `overflow`=1 and `div_zero`=0.
- R9: When the computed biased exponent is below 1, the result is a signed zero and both flags are 0.
- R10: After a synchronous reset, `busy`, `done`, `div_zero` and `overflow` are 0 and `quotient` is 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division; accepted only when idle |
| dividend | input | 32 | Numerator operand |
| divisor | input | 32 | Denominator operand |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| quotient | output | 32 | Registered result word |
| div_zero | output | 1 | Divisor exponent field was zero |
| overflow | output | 1 | Exponent overflow saturated the result |

## Verification
The bench targets the values where this model departs from standard arithmetic.

- **Zero divisor.** 0/0 and x/0 must saturate with the XOR sign. A design that followed the usual rules would return an infinity or NaN pattern there.
- **Exponent 255 and NaN-like codes.** Operands with an exponent of 255 or a NaN-like code must divide as plain numbers. A design that special-cased them would produce non-zero garbage for 0/0x7FC00000.
- **Truncation.** 1/3 must give 0x3EAAAAAA. A rounding design gives 0x3EAAAAAB.
- **Exponent boundaries.** Cases are chosen to cross the overflow and underflow limits. An off-by-one in the normalisation adjustment shows up as a missed clamp or a denormal output pattern.
- **Start while busy.** A start pulse during an operation checks that the design neither restarts nor swaps in the new operands.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  localparam int DEF_EXP_W = 8;
  localparam int DEF_MAN_W = 23;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_LOOP = 1'b1
  } fdiv_state_e;
endpackage

// File: rtl/fdiv_unpack.sv
module fdiv_unpack #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] word,
  output logic                 sign,
  output logic [EXP_W-1:0]     expo,
  output logic [MAN_W:0]       mant,
  output logic                 is_zero
);
  // Exponent field zero means zero or denormal; both are treated as zero.
  assign sign    = word[EXP_W+MAN_W];
  assign expo    = word[EXP_W+MAN_W-1:MAN_W];
  assign is_zero = (expo == '0);
  assign mant    = {1'b1, word[MAN_W-1:0]};
endmodule

// File: rtl/fdiv_mant_core.sv
module fdiv_mant_core #(
  parameter int MAN_W = 23
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [MAN_W:0]   num,
  input  logic [MAN_W:0]   den,
  output logic [MAN_W+1:0] quo,
  output logic             valid
);
  localparam int QB = MAN_W + 2;       // quotient bits incl. normalisation bit
  localparam int RW = MAN_W + 2;       // partial remainder width (< 2*den)
  localparam int CW = $clog2(QB + 1);

  logic [RW-1:0]  rem;
  logic [MAN_W:0] den_r;
  logic [CW-1:0]  cnt;
  logic           run;
  logic [RW-1:0]  diff;
  logic           ge;

  assign ge   = (rem >= RW'(den_r));
  assign diff = rem - RW'(den_r);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem   <= '0;
      den_r <= '0;
      quo   <= '0;
      cnt   <= '0;
      run   <= 1'b0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (load) begin
        rem   <= RW'(num);
        den_r <= den;
        quo   <= '0;
        cnt   <= CW'(QB);
        run   <= 1'b1;
      end else if (run) begin
        // restoring step: subtract when possible, then shift left
        rem <= ge ? {diff[RW-2:0], 1'b0} : {rem[RW-2:0], 1'b0};
        quo <= {quo[QB-2:0], ge};
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run   <= 1'b0;
          valid <= 1'b1;
        end
      end
    end
  end

  // R4: operands lie in [1,2), so one of the top two quotient bits is set
  a_r4_norm_bit: assert property (@(posedge clk) disable iff (rst)
    valid |-> (quo[QB-1] || quo[QB-2]));

  // R1: the loop never runs with an exhausted counter
  a_r1_loop_count: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt != '0));

  // R1: a result is only presented once per loaded operation
  a_r1_valid_once: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
endmodule

// File: rtl/fdiv_pack.sv
module fdiv_pack #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                 sign,
  input  logic [EXP_W-1:0]     exp_a,
  input  logic [EXP_W-1:0]     exp_b,
  input  logic                 a_zero,
  input  logic                 b_zero,
  input  logic [MAN_W+1:0]     q,
  output logic [EXP_W+MAN_W:0] word,
  output logic                 dz,
  output logic                 ovf
);
  localparam int QB   = MAN_W + 2;
  localparam int SW   = EXP_W + 3;
  localparam int BIAS = (2 ** (EXP_W - 1)) - 1;
  localparam int WM1  = EXP_W + MAN_W;
  localparam logic signed [SW-1:0] EMAX_S = SW'((2 ** EXP_W) - 1);

  logic                    norm;
  logic [MAN_W-1:0]        frac;
  logic signed [SW-1:0]    exp_s;
  logic                    e_over;
  logic                    e_under;
  logic [WM1:0]            sat_word;
  logic [WM1:0]            zero_word;

  assign norm  = q[QB-1];
  assign frac  = norm ? q[QB-2:1] : q[QB-3:0];
  assign exp_s = SW'(exp_a) - SW'(exp_b) + SW'(BIAS) - (norm ? SW'(0) : SW'(1));

  assign e_under = exp_s[SW-1] || (exp_s == '0);
  assign e_over  = !exp_s[SW-1] && (exp_s > EMAX_S);

  assign sat_word  = {sign, {WM1{1'b1}}};
  assign zero_word = {sign, {WM1{1'b0}}};

  always_comb begin
    dz  = 1'b0;
    ovf = 1'b0;
    if (b_zero) begin
      word = sat_word;
      dz   = 1'b1;
    end else if (a_zero || e_under) begin
      word = zero_word;
    end else if (e_over) begin
      word = sat_word;
      ovf  = 1'b1;
    end else begin
      word = {sign, exp_s[EXP_W-1:0], frac};
    end
  end
endmodule

// File: rtl/fdiv_top.sv
module fdiv_top
  import fdiv_pkg::*;
#(
  parameter int EXP_W = DEF_EXP_W,
  parameter int MAN_W = DEF_MAN_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [EXP_W+MAN_W:0] dividend,
  input  logic [EXP_W+MAN_W:0] divisor,
  output logic                 busy,
  output logic                 done,
  output logic [EXP_W+MAN_W:0] quotient,
  output logic                 div_zero,
  output logic                 overflow
);
  localparam int W  = EXP_W + MAN_W + 1;
  localparam int QB = MAN_W + 2;

  fdiv_state_e    st;
  logic [W-1:0]   ops   [2];
  logic           sgn   [2];
  logic [EXP_W-1:0] ex  [2];
  logic [MAN_W:0] mn    [2];
  logic           zr    [2];

  assign ops[0] = dividend;
  assign ops[1] = divisor;

  for (genvar i = 0; i < 2; i++) begin : g_unp
    fdiv_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unp (
      .word   (ops[i]),
      .sign   (sgn[i]),
      .expo   (ex[i]),
      .mant   (mn[i]),
      .is_zero(zr[i])
    );
  end

  logic             accept;
  logic             sign_r;
  logic [EXP_W-1:0] ea_r, eb_r;
  logic             az_r, bz_r;
  logic [QB-1:0]    core_q;
  logic             core_valid;
  logic [W-1:0]     pk_word;
  logic             pk_dz, pk_ovf;

  assign accept = (st == ST_IDLE) && start;
  assign busy   = (st == ST_LOOP);

  fdiv_mant_core #(.MAN_W(MAN_W)) u_core (
    .clk  (clk),
    .rst  (rst),
    .load (accept),
    .num  (mn[0]),
    .den  (mn[1]),
    .quo  (core_q),
    .valid(core_valid)
  );

  fdiv_pack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_pack (
    .sign  (sign_r),
    .exp_a (ea_r),
    .exp_b (eb_r),
    .a_zero(az_r),
    .b_zero(bz_r),
    .q     (core_q),
    .word  (pk_word),
    .dz    (pk_dz),
    .ovf   (pk_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      done     <= 1'b0;
      quotient <= '0;
      div_zero <= 1'b0;
      overflow <= 1'b0;
      sign_r   <= 1'b0;
      ea_r     <= '0;
      eb_r     <= '0;
      az_r     <= 1'b0;
      bz_r     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            sign_r <= sgn[0] ^ sgn[1];
            ea_r   <= ex[0];
            eb_r   <= ex[1];
            az_r   <= zr[0];
            bz_r   <= zr[1];
            st     <= ST_LOOP;
          end
        end
        ST_LOOP: begin
          if (core_valid) begin
            quotient <= pk_word;
            div_zero <= pk_dz;
            overflow <= pk_ovf;
            done     <= 1'b1;
            st       <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R1: done is a single-cycle pulse and the block is idle when it shows
  a_r1_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r1_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R1: result word is frozen during an operation
  a_r1_hold_result: assert property (@(posedge clk) disable iff (rst)
    busy |-> $stable(quotient));
  // R2: an operation begins only from a start request
  a_r2_start_gated: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  // R5: zero divisor saturates and never reports overflow
  a_r5_dz_sat: assert property (@(posedge clk) disable iff (rst)
    (done && div_zero) |-> ((&quotient[W-2:0]) && !overflow));
  // R8: overflow saturates the magnitude
  a_r8_ovf_sat: assert property (@(posedge clk) disable iff (rst)
    (done && overflow) |-> (&quotient[W-2:0]));
  // R9: an ordinary result with a zero exponent field is an exact zero
  a_r9_no_denorm: assert property (@(posedge clk) disable iff (rst)
    (done && !div_zero && !overflow && (quotient[W-2:MAN_W] == '0))
      |-> (quotient[MAN_W-1:0] == '0));
endmodule

// File: tb/fdiv_top_test.sv
module fdiv_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic        busy, done, div_zero, overflow;
  logic [31:0] quotient;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  localparam int LAT = 26;

  always #5 clk = ~clk;

  fdiv_top uut (
    .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient), .div_zero(div_zero),
    .overflow(overflow)
  );

  // expected {dz, ovf, word} from the requirement text
  function automatic logic [33:0] ref_div(input logic [31:0] a, input logic [31:0] b);
    logic s;
    int ea, eb, e;
    longint unsigned ma, mb, q;
    logic [22:0] fr;
    s  = a[31] ^ b[31];
    ea = int'(a[30:23]);
    eb = int'(b[30:23]);
    if (eb == 0) return {2'b10, s, 31'h7FFFFFFF};
    if (ea == 0) return {2'b00, s, 31'h0};
    ma = 64'h800000 | 64'(a[22:0]);
    mb = 64'h800000 | 64'(b[22:0]);
    q  = (ma << 24) / mb;
    if (q[24]) begin fr = q[23:1]; e = ea - eb + 127; end
    else       begin fr = q[22:0]; e = ea - eb + 126; end
    if (e > 255) return {2'b01, s, 31'h7FFFFFFF};
    if (e < 1)   return {2'b00, s, 31'h0};
    return {2'b00, s, e[7:0], fr};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                        input string req, input bit inject);
    logic [33:0] e;
    int cyc;
    e = ref_div(a, b);
    @(negedge clk);
    dividend = a; divisor = b; start = 1'b1;
    @(negedge clk);
    cyc = 0;
    chk(busy == 1'b1, "R1", "busy after accept", 64'(busy), 64'd1);
    if (inject) begin
      dividend = ~a; divisor = 32'h3F800000;
    end else start = 1'b0;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
      if (cyc >= 4) start = 1'b0;
    end
    start = 1'b0;
    chk(cyc == LAT, inject ? "R2" : "R1", "latency", 64'(cyc), 64'(LAT));
    chk(quotient == e[31:0], req, $sformatf("word %h/%h", a, b), 64'(quotient), 64'(e[31:0]));
    chk({div_zero, overflow} == e[33:32], req, "flags",
        64'({div_zero, overflow}), 64'(e[33:32]));
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, inject ? "R2" : "R1", "done pulse width",
        64'({done, busy}), 64'd0);
  endtask

  function automatic logic [31:0] rnd_op(input int mode);
    logic [31:0] r;
    r = $urandom;
    case (mode)
      0: ;
      1: r[30:23] = 8'(240 + ($urandom % 16));
      2: r[30:23] = 8'(1 + ($urandom % 16));
      default: r[30:23] = 8'(110 + ($urandom % 36));
    endcase
    return r;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk(!busy && !done && !div_zero && !overflow && quotient == 32'h0, "R10",
        "reset state", 64'({busy, done, div_zero, overflow, quotient}), 64'd0);

    run_op(32'h3F800000, 32'h3F800000, "R4", 0);
    run_op(32'h40400000, 32'h3F800000, "R4", 0);
    run_op(32'h3F800000, 32'h40400000, "R4", 0); // 1/3 -> 3EAAAAAA truncated
    run_op(32'hBF800000, 32'h3F800000, "R3", 0);
    run_op(32'hC0000000, 32'hC0400000, "R3", 0);
    run_op(32'h3F800000, 32'h00000000, "R5", 0);
    run_op(32'h00000000, 32'h00000000, "R5", 0);
    run_op(32'hBF800000, 32'h00000000, "R5", 0); // R3 sign on saturation
    run_op(32'h40000000, 32'h00000001, "R5", 0);
    run_op(32'h00000000, 32'h7FC00000, "R7", 0);
    run_op(32'h7F800000, 32'h3F800000, "R7", 0);
    run_op(32'h7FC00000, 32'h7FC00000, "R7", 0);
    run_op(32'h00400000, 32'h3F800000, "R6", 0);
    run_op(32'h80000000, 32'h3F800000, "R6", 0);
    run_op(32'h7F000000, 32'h00800000, "R8", 0);
    run_op(32'hFF7FFFFF, 32'h00800000, "R8", 0);
    run_op(32'h00800000, 32'h7F000000, "R9", 0);
    run_op(32'h80800000, 32'h7F000000, "R9", 0);
    run_op(32'h3F800000, 32'h7F800000, "R9", 0);
    run_op(32'h40A00000, 32'h40000000, "R2", 1);
    run_op(32'h3FC00000, 32'hBF400000, "R2", 1);

    for (int i = 0; i < 400; i++) begin
      run_op(rnd_op(i % 4), rnd_op((i / 4) % 4), "R4", (i % 37) == 0);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule